// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Select

This block is a 16-bit pulse accumulator that sits beside a free-running timer. In edge-count mode it adds one for every edge of the chosen polarity on a single input pin. In gated mode the pin acts as a gate: while the pin holds its active level, each divide-by-64 tick from the timer prescaler adds one. The edge that ends the gate interval raises an input flag. The input pin is synchronised inside the block, so it may be driven from outside the clock domain.

The accumulator also produces the clock enable for the main timer counter. The timer counter can run from the prescaler tick, from every accumulator tick, from every 256th accumulator tick, or from every 65536th accumulator tick. When the accumulator is disabled, the prescaler tick is always used. The block has two sticky flags: input and overflow. Software clears each flag by writing one to it. An interrupt request is raised whenever an enabled flag is set.

Top module: `pacc_unit`

## Requirements
- R1: After reset, count_o is 0x0000, both flags are 0, irq_o is 0 and tcnt_tick_o is 0.
- R2: In edge-count mode (gated_mode_i=0) with acc_en_i=1, polarity_i=0 counts each falling edge of pin_i and polarity_i=1 counts each rising edge. Each edge counts exactly once. The new count appears on count_o three clock edges after pin_i changes: two synchroniser stages and then the count register.
- R3: In gated mode (gated_mode_i=1) with acc_en_i=1 and timer_en_i=1, each cycle with div64_tick_i=1 adds one to the count while the synchronised pin is at the active level. The active level is high for polarity_i=0 and low for polarity_i=1. At the inactive level, ticks are ignored, and the edge that starts a gate interval sets no flag.
- R4: The input flag is set by the falling edge (polarity_i=0) or the rising edge (polarity_i=1) of the synchronised pin. In edge-count mode this is the counted edge. In gated mode it is the trailing edge of the gate interval.
- R5: While timer_en_i=0, div64_tick_i is ignored and gated accumulation does not advance.
- R6: While acc_en_i=0, the count and both flags are never changed by pin activity, whatever polarity_i is. In this state tcnt_tick_o equals presc_tick_i delayed by one cycle, whatever clk_sel_i holds.
- R7: An accumulator tick that takes the count from 0xFFFF to 0x0000 sets the overflow flag.
- R8: A 1 on clr_inp_i or clr_ovf_i clears the matching flag on the next edge. If a set event occurs in the same cycle, the set wins and the flag stays 1.
- R9: irq_o is 1 exactly when (ovf_ie_i and the overflow flag) or (inp_ie_i and the input flag).
- R10: With acc_en_i=1, tcnt_tick_o is registered from clk_sel_i as follows. 2'b00 gives the prescaler tick. 2'b01 gives every accumulator tick. 2'b10 gives the tick that moves the low count byte from 0xFF to 0x00. 2'b11 gives the tick that wraps the count. A tick is emitted in the same cycle that count_o shows the new value. A new clk_sel_i value takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Accumulator input pin, asynchronous |
| timer_en_i | input | 1 | Timer running; gates the divide-by-64 tick |
| presc_tick_i | input | 1 | Timer prescaler tick, one cycle wide |
| div64_tick_i | input | 1 | Bus clock divided by 64 tick from the prescaler |
| acc_en_i | input | 1 | Accumulator enable |
| gated_mode_i | input | 1 | 0 edge-count, 1 gated time accumulation |
| polarity_i | input | 1 | Edge or level polarity select |
| clk_sel_i | input | 2 | Timer counter clock select |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| inp_ie_i | input | 1 | Input-flag interrupt enable |
| clr_inp_i | input | 1 | Write-one-to-clear strobe for the input flag |
| clr_ovf_i | input | 1 | Write-one-to-clear strobe for the overflow flag |
| count_o | output | 16 | Accumulator count |
| inp_flag_o | output | 1 | Input flag |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |
| tcnt_tick_o | output | 1 | Clock enable for the main timer counter |

## Verification
The bench drives a full 65536-tick wrap with the slowest clock select. A design that sets overflow on the wrong value, or that emits the divided tick more than once per wrap, shows the wrong flag or the wrong pulse count. It runs clears in the same cycle as a set edge, so a design that lets the clear win drops the flag. It drives a gate's leading edge and ticks at the inactive level, so a design that confuses leading and trailing edges, or ignores the level, sets the flag early or counts extra. It toggles the pin with the accumulator disabled and with the timer stopped, and switches the select while the prescaler tick is held high. This catches designs that leak counts or that lag the select by a cycle.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    // Timer counter clock source; encoding is decoded by pacc_clksel
    typedef enum logic [1:0] {
        TSRC_PRESC    = 2'b00,
        TSRC_ACC      = 2'b01,
        TSRC_ACC_LO   = 2'b10,
        TSRC_ACC_WRAP = 2'b11
    } tsrc_e;

    // Synchronised pin events
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_evt_t;

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    output pacc_pkg::pin_evt_t evt_o
);
    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } state_t;

    state_t q, d;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                d      = q;
                d.sh   = {q.sh[STAGES-2:0], pin_i};
                d.prev = q.sh[TOP];
            end
        end else begin : g_single
            always_comb begin
                d      = q;
                d.sh   = pin_i;
                d.prev = q.sh[TOP];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        evt_o.level = q.sh[TOP];
        evt_o.rise  = q.sh[TOP] & ~q.prev;
        evt_o.fall  = ~q.sh[TOP] & q.prev;
    end

endmodule

// File: rtl/pacc_core.sv
module pacc_core #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LO_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               gated_i,
    input  logic               pol_i,
    input  pacc_pkg::pin_evt_t evt_i,
    input  logic               div64_i,
    input  logic               clr_inp_i,
    input  logic               clr_ovf_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               inp_o,
    output logic               ovf_o,
    output logic               tick_o,
    output logic               lo_carry_o,
    output logic               wrap_o
);
    localparam int unsigned PAD_W = CNT_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             inp;
        logic             ovf;
    } state_t;

    state_t q, d;
    logic   edge_sel, gate_on, tick, wrap;

    always_comb begin
        // Same edge is counted in edge mode and ends the gate in gated mode
        edge_sel = pol_i ? evt_i.rise : evt_i.fall;
        gate_on  = pol_i ? ~evt_i.level : evt_i.level;
        tick     = en_i & (gated_i ? (gate_on & div64_i) : edge_sel);
        wrap     = tick & (&q.cnt);

        d     = q;
        d.cnt = q.cnt + {{PAD_W{1'b0}}, tick};
        d.inp = (en_i & edge_sel) | (q.inp & ~clr_inp_i);
        d.ovf = wrap | (q.ovf & ~clr_ovf_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o      = q.cnt;
    assign inp_o      = q.inp;
    assign ovf_o      = q.ovf;
    assign tick_o     = tick;
    assign lo_carry_o = tick & (&q.cnt[LO_W-1:0]);
    assign wrap_o     = wrap;

endmodule

// File: rtl/pacc_clksel.sv
module pacc_clksel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] sel_i,
    input  logic       presc_i,
    input  logic       acc_tick_i,
    input  logic       lo_carry_i,
    input  logic       wrap_i,
    output logic       tick_o
);
    import pacc_pkg::*;

    typedef struct packed {
        logic tick;
    } state_t;

    state_t q, d;
    tsrc_e  src;

    always_comb begin
        src = en_i ? tsrc_e'(sel_i) : TSRC_PRESC;
        d   = q;
        unique case (src)
            TSRC_PRESC:    d.tick = presc_i;
            TSRC_ACC:      d.tick = acc_tick_i;
            TSRC_ACC_LO:   d.tick = lo_carry_i;
            TSRC_ACC_WRAP: d.tick = wrap_i;
            default:       d.tick = presc_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;

endmodule

// File: rtl/pacc_unit.sv
module pacc_unit #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned LO_W        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             timer_en_i,
    input  logic             presc_tick_i,
    input  logic             div64_tick_i,
    input  logic             acc_en_i,
    input  logic             gated_mode_i,
    input  logic             polarity_i,
    input  logic [1:0]       clk_sel_i,
    input  logic             ovf_ie_i,
    input  logic             inp_ie_i,
    input  logic             clr_inp_i,
    input  logic             clr_ovf_i,
    output logic [CNT_W-1:0] count_o,
    output logic             inp_flag_o,
    output logic             ovf_flag_o,
    output logic             irq_o,
    output logic             tcnt_tick_o
);
    pacc_pkg::pin_evt_t evt;
    logic acc_tick, lo_carry, wrap, div64_live;

    // The divide-by-64 tick only exists while the timer runs
    assign div64_live = div64_tick_i & timer_en_i;

    pacc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .evt_o (evt)
    );

    pacc_core #(.CNT_W(CNT_W), .LO_W(LO_W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (acc_en_i),
        .gated_i    (gated_mode_i),
        .pol_i      (polarity_i),
        .evt_i      (evt),
        .div64_i    (div64_live),
        .clr_inp_i  (clr_inp_i),
        .clr_ovf_i  (clr_ovf_i),
        .cnt_o      (count_o),
        .inp_o      (inp_flag_o),
        .ovf_o      (ovf_flag_o),
        .tick_o     (acc_tick),
        .lo_carry_o (lo_carry),
        .wrap_o     (wrap)
    );

    pacc_clksel i_clksel (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (acc_en_i),
        .sel_i      (clk_sel_i),
        .presc_i    (presc_tick_i),
        .acc_tick_i (acc_tick),
        .lo_carry_i (lo_carry),
        .wrap_i     (wrap),
        .tick_o     (tcnt_tick_o)
    );

    assign irq_o = (ovf_ie_i & ovf_flag_o) | (inp_ie_i & inp_flag_o);

endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_en_i,
    input logic             presc_tick_i,
    input logic             clr_inp_i,
    input logic [CNT_W-1:0] count_o,
    input logic             inp_flag_o,
    input logic             ovf_flag_o,
    input logic             irq_o,
    input logic             tcnt_tick_o
);
    // R6: disabled accumulator holds its count
    assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en_i |=> $stable(count_o));

    // R6: disabled accumulator forwards the prescaler tick
    assert_presc_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en_i |=> (tcnt_tick_o == $past(presc_tick_i)));

    // R2: count only ever steps by one
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1));

    // R7: overflow flag rises only on a wrap
    assert_ovf_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag_o) |-> ((count_o == '0) && ($past(count_o) == '1)));

    // R8: input flag falls only after a clear strobe
    assert_inp_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inp_flag_o) |-> $past(clr_inp_i));

    // R9: no request without a flag
    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (inp_flag_o || ovf_flag_o));

endmodule

bind pacc_unit pacc_checker #(.CNT_W(CNT_W)) i_pacc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_en_i     (acc_en_i),
    .presc_tick_i (presc_tick_i),
    .clr_inp_i    (clr_inp_i),
    .count_o      (count_o),
    .inp_flag_o   (inp_flag_o),
    .ovf_flag_o   (ovf_flag_o),
    .irq_o        (irq_o),
    .tcnt_tick_o  (tcnt_tick_o)
);

// File: tb/test_pacc_unit.sv
module test_pacc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0, timer_en = 1'b0, presc = 1'b0, div64 = 1'b0;
    logic        acc_en = 1'b0, gated = 1'b0, pol = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic        ovf_ie = 1'b0, inp_ie = 1'b0, clr_inp = 1'b0, clr_ovf = 1'b0;
    logic [15:0] count;
    logic        inp_flag, ovf_flag, irq, tcnt;

    int checks = 0;
    int errors = 0;
    int ticks_seen = 0;
    logic [15:0] exp_cnt = '0;

    always #5 clk = ~clk;

    pacc_unit i_pacc_unit (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .timer_en_i(timer_en),
        .presc_tick_i(presc), .div64_tick_i(div64), .acc_en_i(acc_en),
        .gated_mode_i(gated), .polarity_i(pol), .clk_sel_i(sel),
        .ovf_ie_i(ovf_ie), .inp_ie_i(inp_ie), .clr_inp_i(clr_inp),
        .clr_ovf_i(clr_ovf), .count_o(count), .inp_flag_o(inp_flag),
        .ovf_flag_o(ovf_flag), .irq_o(irq), .tcnt_tick_o(tcnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance n negedges, tallying timer ticks
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tcnt) ticks_seen++;
        end
    endtask

    task automatic pin_to(input logic v);
        pin = v;
        step(4);
    endtask

    task automatic clear_flags();
        clr_inp = 1'b1; clr_ovf = 1'b1;
        step(1);
        clr_inp = 1'b0; clr_ovf = 1'b0;
        step(1);
    endtask

    task automatic gated_ticks(input int n);
        div64 = 1'b1;
        step(n);
        div64 = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 inp flag", inp_flag, 0);
        chk("R1 ovf flag", ovf_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tick", tcnt, 0);
    endtask

    task automatic t_event_fall();
        acc_en = 1'b1; gated = 1'b0; pol = 1'b0; sel = 2'b01;
        step(1);
        ticks_seen = 0;
        for (int k = 0; k < 5; k++) begin
            pin_to(1'b1);
            pin_to(1'b0);
        end
        exp_cnt += 5;
        chk("R2 falling edges counted", count, exp_cnt);
        chk("R10 sel01 tick per edge", ticks_seen, 5);
        chk("R4 event edge sets inp flag", inp_flag, 1);
    endtask

    task automatic t_event_rise();
        pol = 1'b1;
        clear_flags();
        // Exact latency: count moves on the third edge after the pin change
        pin = 1'b1;
        step(2);
        chk("R2 not yet counted", count, exp_cnt);
        step(1);
        exp_cnt += 1;
        chk("R2 rising edge latency", count, exp_cnt);
        pin_to(1'b0);
        pin_to(1'b1);
        pin_to(1'b0);
        exp_cnt += 1;
        chk("R2 rising edges counted once", count, exp_cnt);
    endtask

    task automatic t_gated_high();
        gated = 1'b1; pol = 1'b0; timer_en = 1'b1; sel = 2'b00;
        clear_flags();
        pin_to(1'b1);
        chk("R3 leading edge sets no flag", inp_flag, 0);
        gated_ticks(10);
        exp_cnt += 10;
        chk("R3 high gate accumulates", count, exp_cnt);
        pin_to(1'b0);
        chk("R4 trailing falling edge flag", inp_flag, 1);
        gated_ticks(10);
        chk("R3 low level ignored pol0", count, exp_cnt);
    endtask

    task automatic t_gated_low();
        pol = 1'b1;
        clear_flags();
        gated_ticks(7);
        exp_cnt += 7;
        chk("R3 low gate accumulates", count, exp_cnt);
        pin_to(1'b1);
        chk("R4 trailing rising edge flag", inp_flag, 1);
        pin_to(1'b0);
    endtask

    task automatic t_timer_off();
        timer_en = 1'b0;
        gated_ticks(10);
        chk("R5 timer off no accumulation", count, exp_cnt);
        timer_en = 1'b1;
    endtask

    task automatic t_disabled();
        clear_flags();
        acc_en = 1'b0; gated = 1'b0; sel = 2'b11;
        pol = 1'b0;
        pin_to(1'b1);
        pin_to(1'b0);
        pol = 1'b1;
        pin_to(1'b1);
        pin_to(1'b0);
        chk("R6 disabled count held", count, exp_cnt);
        chk("R6 disabled flag untouched", inp_flag, 0);
        ticks_seen = 0;
        for (int k = 0; k < 5; k++) begin
            presc = 1'b1; step(1);
            presc = 1'b0; step(2);
        end
        chk("R6 prescaler tick forwarded", ticks_seen, 5);
        acc_en = 1'b1;
    endtask

    task automatic t_clear_race();
        gated = 1'b0; pol = 1'b1;
        clr_inp = 1'b0;
        pin = 1'b1;
        step(2);
        clr_inp = 1'b1;
        step(1);
        clr_inp = 1'b0;
        exp_cnt += 1;
        chk("R8 set beats clear", inp_flag, 1);
        step(2);
        clr_inp = 1'b1; step(1); clr_inp = 1'b0;
        chk("R8 clear alone", inp_flag, 0);
        pin_to(1'b0);
        chk("R8 polarity1 falling not flagged", inp_flag, 0);
    endtask

    task automatic t_irq();
        pin_to(1'b1);
        exp_cnt += 1;
        pin_to(1'b0);
        inp_ie = 1'b0; step(1);
        chk("R9 irq masked", irq, 0);
        inp_ie = 1'b1; step(1);
        chk("R9 irq input source", irq, 1);
        clear_flags();
        chk("R9 irq drops with flag", irq, 0);
        inp_ie = 1'b0;
    endtask

    task automatic t_sel_switch();
        presc = 1'b1; sel = 2'b00;
        step(2);
        chk("R10 sel00 prescaler", tcnt, 1);
        sel = 2'b01;
        step(1);
        chk("R10 sel change next cycle", tcnt, 0);
        sel = 2'b00;
        step(1);
        chk("R10 sel back next cycle", tcnt, 1);
        presc = 1'b0;
        step(1);
    endtask

    task automatic t_sel_lo();
        int exp_ticks = 0;
        logic [15:0] c;
        gated = 1'b1; pol = 1'b0; sel = 2'b10;
        pin_to(1'b1);
        c = exp_cnt;
        for (int k = 0; k < 600; k++) begin
            c = c + 16'd1;
            if (c[7:0] == 8'h00) exp_ticks++;
        end
        ticks_seen = 0;
        gated_ticks(600);
        exp_cnt += 600;
        chk("R10 sel10 low byte carry ticks", ticks_seen, exp_ticks);
        chk("R3 gated count after run", count, exp_cnt);
    endtask

    task automatic t_wrap();
        int n;
        n = 65536 - int'(exp_cnt) + 5;
        sel = 2'b11; ovf_ie = 1'b1;
        chk("R7 no overflow yet", ovf_flag, 0);
        ticks_seen = 0;
        gated_ticks(n);
        exp_cnt = 16'd5;
        chk("R7 count after wrap", count, exp_cnt);
        chk("R7 overflow flag set", ovf_flag, 1);
        chk("R10 sel11 one tick per wrap", ticks_seen, 1);
        chk("R9 irq overflow source", irq, 1);
        clr_ovf = 1'b1; step(1); clr_ovf = 1'b0; step(1);
        chk("R8 overflow cleared", ovf_flag, 0);
        ovf_ie = 1'b0;
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        t_event_fall();
        t_event_rise();
        t_gated_high();
        t_gated_low();
        t_timer_off();
        t_disabled();
        t_clear_race();
        t_irq();
        t_sel_switch();
        t_sel_lo();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule